// File: doc/BRIEF.md
# Four-Candidate Vote Winner Display

This block takes the running vote totals of four candidates and works out which one leads. The lead is settled by a small knockout: candidate 0 meets candidate 1, and candidate 2 meets candidate 3. In each pairing a magnitude comparator steers a multiplexer, which passes the larger total and the index that goes with it. A third comparator then decides between the two pairing winners.

The result is shown as one decimal digit, 0 to 3, on a seven-segment display. The digit is driven only while the show request is held high. At all other times every segment stays dark. A valid flag follows the show request, so downstream logic can tell a blank display from a result.

A parameter selects whether the outputs leave through a register stage (one cycle of latency) or come straight from the logic.

Top module: `winner_display`

## Requirements
- R1: While shown, the digit equals the index of the candidate with the strictly largest count. Indices are 0 for `cnt_a`, 1 for `cnt_b`, 2 for `cnt_c` and 3 for `cnt_d`.
- R2: When two or more candidates share the largest count, the one with the lowest index among them is shown. This applies within each pairing and in the final round.
- R3: While `show_req` is low, `seg` is 7'b0000000 (all segments dark).
- R4: `valid` equals `show_req`, subject to the same latency as `seg`.
- R5: `seg` is active-high with bit 0 = segment a through bit 6 = segment g. The digit patterns are: 0 = 7'b0111111, 1 = 7'b0000110, 2 = 7'b1011011, 3 = 7'b1001111.
- R6: With `REG_OUT`=1 (the default), outputs reflect the inputs sampled at the previous rising clock edge. A clock edge with `rst_n` low drives `seg` to 0 and `valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_a | input | CNT_W | Vote count of candidate 0 |
| cnt_b | input | CNT_W | Vote count of candidate 1 |
| cnt_c | input | CNT_W | Vote count of candidate 2 |
| cnt_d | input | CNT_W | Vote count of candidate 3 |
| show_req | input | 1 | Level request to display the winner |
| seg | output | 7 | Segment lines, bit 0 = a to bit 6 = g, active-high |
| valid | output | 1 | High while a winner digit is displayed |

## Verification
Directed patterns come first, with one candidate uniquely ahead in each position. These separate the index paths from one another. Ties follow: inside the first pairing, inside the second pairing, across the final round, and all four equal. These expose a comparator that uses the wrong strictness or a final multiplexer with reversed priority. All-zero and all-maximum counts probe the ends of the count range. Random counts are then applied, with `show_req` toggled, to mix blanking into every state and catch gating that leaks segments.

// File: rtl/winner_pkg.sv
// Package winner_pkg
// Shared types and constants for the winner display block.
// Assumes exactly four candidates, so an index fits in two bits.
package winner_pkg;
    localparam int NUM_CAND   = 4;
    localparam int CAND_IDX_W = $clog2(NUM_CAND);
    localparam int SEG_W      = 7;

    typedef logic [CAND_IDX_W-1:0] cand_idx_t;
    typedef logic [SEG_W-1:0]      seg_t;

    localparam seg_t SEG_DARK = '0;
endpackage

// File: rtl/wd_pair_round.sv
// Module wd_pair_round
// One first-round match: compares two counts and forwards the larger one
// together with its candidate index. The low-index side wins ties.
// Assumes both counts are unsigned and of equal width.
module wd_pair_round
    import winner_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] lo_cnt,
    input  cand_idx_t        lo_idx,
    input  logic [CNT_W-1:0] hi_cnt,
    input  cand_idx_t        hi_idx,
    output logic [CNT_W-1:0] win_cnt,
    output cand_idx_t        win_idx
);
    logic hi_ahead;

    // Comparator: the high-index side needs a strict lead to win.
    always_comb hi_ahead = (hi_cnt > lo_cnt);

    // Multiplexer: pass the winning count and index forward.
    always_comb begin
        win_cnt = hi_ahead ? hi_cnt : lo_cnt;
        win_idx = hi_ahead ? hi_idx : lo_idx;
    end
endmodule

// File: rtl/wd_final_round.sv
// Module wd_final_round
// Final match between the two pairing winners. Produces only the overall
// winning index. The first pairing's winner holds on a tie, because it
// carries the lower indices.
module wd_final_round
    import winner_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] left_cnt,
    input  cand_idx_t        left_idx,
    input  logic [CNT_W-1:0] right_cnt,
    input  cand_idx_t        right_idx,
    output cand_idx_t        champ_idx
);
    // Third comparator and index select.
    always_comb champ_idx = (right_cnt > left_cnt) ? right_idx : left_idx;
endmodule

// File: rtl/wd_seg_encoder.sv
// Module wd_seg_encoder
// Turns a candidate index into an active-high seven-segment pattern
// (bit 0 = a ... bit 6 = g). Drives all segments dark while blank is set.
module wd_seg_encoder
    import winner_pkg::*;
(
    input  cand_idx_t idx,
    input  logic      blank,
    output seg_t      seg
);
    // Digit lookup with blanking override.
    always_comb begin
        if (blank) begin
            seg = SEG_DARK;
        end else begin
            unique case (idx)
                2'd0:    seg = 7'b0111111;
                2'd1:    seg = 7'b0000110;
                2'd2:    seg = 7'b1011011;
                default: seg = 7'b1001111;
            endcase
        end
    end
endmodule

// File: rtl/winner_display.sv
// Module winner_display
// Finds the leading candidate among four vote counts with a two-level
// knockout (two pairing rounds, one final) and shows the index as a digit
// while show_req is high. With REG_OUT=1 the outputs are registered and
// cleared by a synchronous active-low reset. With REG_OUT=0 they are
// combinational.
module winner_display
    import winner_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [CNT_W-1:0] cnt_c,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             show_req,
    output logic [6:0]       seg,
    output logic             valid
);
    localparam int PAIRS = NUM_CAND / 2;

    logic [CNT_W-1:0] cnt_vec   [NUM_CAND];
    logic [CNT_W-1:0] pair_cnt  [PAIRS];
    cand_idx_t        pair_idx  [PAIRS];
    cand_idx_t        champ_idx;
    seg_t             seg_next;

    // Gather the four counts in candidate order.
    always_comb begin
        cnt_vec[0] = cnt_a;
        cnt_vec[1] = cnt_b;
        cnt_vec[2] = cnt_c;
        cnt_vec[3] = cnt_d;
    end

    // First round: one comparator plus multiplexer per pairing.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        wd_pair_round #(.CNT_W(CNT_W)) u_round (
            .lo_cnt  (cnt_vec[2*p]),
            .lo_idx  (cand_idx_t'(2*p)),
            .hi_cnt  (cnt_vec[2*p+1]),
            .hi_idx  (cand_idx_t'(2*p+1)),
            .win_cnt (pair_cnt[p]),
            .win_idx (pair_idx[p])
        );
    end

    wd_final_round #(.CNT_W(CNT_W)) u_final (
        .left_cnt  (pair_cnt[0]),
        .left_idx  (pair_idx[0]),
        .right_cnt (pair_cnt[1]),
        .right_idx (pair_idx[1]),
        .champ_idx (champ_idx)
    );

    wd_seg_encoder u_enc (
        .idx   (champ_idx),
        .blank (!show_req),
        .seg   (seg_next)
    );

    if (REG_OUT) begin : g_reg
        // Output stage: register segments and valid, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg   <= SEG_DARK;
                valid <= 1'b0;
            end else begin
                seg   <= seg_next;
                valid <= show_req;
            end
        end
    end else begin : g_comb
        // Output stage: pass the logic straight through.
        always_comb begin
            seg   = seg_next;
            valid = show_req;
        end
    end
endmodule

// File: rtl/wd_checker.sv
// Module wd_checker
// Property checks for winner_display, attached with bind. Decodes the
// displayed digit and verifies it against the counts that produced it.
module wd_checker #(
    parameter int CNT_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [CNT_W-1:0] cnt_c,
    input logic [CNT_W-1:0] cnt_d,
    input logic             show_req,
    input logic [6:0]       seg,
    input logic             valid
);
    logic [CNT_W-1:0] obs [4];
    logic [1:0]       shown;
    logic             known;
    logic             lead_ok;
    logic             low_ok;

    if (REG_OUT) begin : g_cap
        // Hold the counts that the registered output belongs to.
        always_ff @(posedge clk) begin
            obs[0] <= cnt_a;
            obs[1] <= cnt_b;
            obs[2] <= cnt_c;
            obs[3] <= cnt_d;
        end
    end else begin : g_live
        // Combinational output: compare against the live counts.
        always_comb begin
            obs[0] = cnt_a;
            obs[1] = cnt_b;
            obs[2] = cnt_c;
            obs[3] = cnt_d;
        end
    end

    // Decode the digit and judge whether it marks the leader.
    always_comb begin
        known = 1'b1;
        shown = 2'd0;
        case (seg)
            7'b0111111: shown = 2'd0;
            7'b0000110: shown = 2'd1;
            7'b1011011: shown = 2'd2;
            7'b1001111: shown = 2'd3;
            default:    known = 1'b0;
        endcase
        lead_ok = 1'b1;
        low_ok  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (obs[k] > obs[shown]) lead_ok = 1'b0;
            if (k < int'(shown) && obs[k] == obs[shown]) low_ok = 1'b0;
        end
    end

    if (REG_OUT) begin : g_props
        assert_digit_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
            valid |-> known);
        assert_dark_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !valid |-> seg == 7'b0000000);
        assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> valid == $past(show_req));
        assert_leader_shown_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && known) |-> lead_ok);
        assert_low_index_tie_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && known) |-> low_ok);
        assert_reset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (seg == 7'b0000000 && !valid));
    end else begin : g_imm
        // Combinational variant: immediate checks after inputs settle.
        always_comb begin
            if (rst_n) begin
                assert_valid_follows_R4_c: assert (valid == show_req);
                if (valid) begin
                    assert_digit_known_R5_c: assert (known);
                    assert_leader_shown_R1_c: assert (lead_ok && low_ok);
                end else begin
                    assert_dark_when_idle_R3_c: assert (seg == 7'b0000000);
                end
            end
        end
    end
endmodule

bind winner_display wd_checker #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_wd_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .cnt_c    (cnt_c),
    .cnt_d    (cnt_d),
    .show_req (show_req),
    .seg      (seg),
    .valid    (valid)
);

// File: tb/tb_winner_display.sv
// Bench for winner_display (REG_OUT=1). Inputs change on falling edges.
// A behavioural model updates on rising edges, and the outputs are compared
// with it on every falling edge.
module tb_winner_display;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] cnt_a, cnt_b, cnt_c, cnt_d;
    logic             show_req;
    logic [6:0]       seg;
    logic             valid;

    logic [6:0] exp_seg;
    logic       exp_valid;
    logic       exp_tie;
    logic       chk_en = 1'b0;
    int         n_vec  = 0;
    int         n_bad  = 0;
    int         cycles = 0;
    bit         done   = 1'b0;

    winner_display #(.CNT_W(CNT_W), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c), .cnt_d(cnt_d),
        .show_req(show_req), .seg(seg), .valid(valid)
    );

    always #5 clk = ~clk;

    // Digit patterns from R5: bit 0 = a ... bit 6 = g.
    function automatic logic [6:0] digit_pat(int d);
        case (d)
            0:       return 7'b0111111;
            1:       return 7'b0000110;
            2:       return 7'b1011011;
            default: return 7'b1001111;
        endcase
    endfunction

    // Reference model: scan for the first maximum (R1, R2); register per R6.
    always @(posedge clk) begin
        int v[4];
        int best;
        int nmax;
        v[0] = cnt_a; v[1] = cnt_b; v[2] = cnt_c; v[3] = cnt_d;
        best = 0;
        for (int i = 1; i < 4; i++) if (v[i] > v[best]) best = i;
        nmax = 0;
        for (int i = 0; i < 4; i++) if (v[i] == v[best]) nmax++;
        if (!rst_n) begin
            exp_seg   <= 7'b0;
            exp_valid <= 1'b0;
            exp_tie   <= 1'b0;
        end else begin
            exp_seg   <= show_req ? digit_pat(best) : 7'b0;
            exp_valid <= show_req;
            exp_tie   <= (nmax > 1);
        end
        chk_en <= 1'b1;
    end

    // Compare on the falling edge, away from the register update.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_vec++;
            if (valid !== exp_valid) begin
                n_bad++;
                $display("FAIL R4: valid=%b expected %b", valid, exp_valid);
            end
            if (seg !== exp_seg) begin
                n_bad++;
                if (!rst_n || exp_seg == 7'b0)
                    $display("FAIL R3/R6: seg=%b expected %b", seg, exp_seg);
                else if (exp_tie)
                    $display("FAIL R2: seg=%b expected %b", seg, exp_seg);
                else
                    $display("FAIL R1/R5: seg=%b expected %b", seg, exp_seg);
            end
        end
    end

    task automatic put(int a, int b, int c, int d, bit s);
        @(negedge clk);
        cnt_a = CNT_W'(a); cnt_b = CNT_W'(b); cnt_c = CNT_W'(c); cnt_d = CNT_W'(d);
        show_req = s;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected under 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cnt_a = '0; cnt_b = '0; cnt_c = '0; cnt_d = '0;
        show_req = 1'b1;             // R6: reset must still hold outputs dark
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1/R5: unique leader in each position
        put(9, 2, 3, 4, 1'b1);
        put(1, 7, 3, 4, 1'b1);
        put(1, 2, 12, 4, 1'b1);
        put(1, 2, 3, 15, 1'b1);
        // R2: ties inside each pairing, across the final, all equal
        put(6, 6, 1, 2, 1'b1);
        put(1, 2, 8, 8, 1'b1);
        put(5, 3, 5, 1, 1'b1);
        put(2, 9, 1, 9, 1'b1);
        put(3, 3, 3, 3, 1'b1);
        put(0, 0, 0, 0, 1'b1);
        put(15, 15, 15, 15, 1'b1);
        // R3/R4: request low hides a clear leader
        put(1, 2, 3, 15, 1'b0);
        put(14, 0, 0, 0, 1'b0);
        put(14, 0, 0, 0, 1'b1);
        // R6: reset in mid-run clears the outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        // Random mix of counts and request levels
        for (int n = 0; n < 400; n++) begin
            put($urandom_range(15), $urandom_range(15), $urandom_range(15),
                $urandom_range(15), ($urandom_range(3) != 0));
        end
        // Small range to force frequent ties (R2)
        for (int n = 0; n < 200; n++) begin
            put($urandom_range(2), $urandom_range(2), $urandom_range(2),
                $urandom_range(2), 1'b1);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule